// File: doc/BRIEF.md
# Hierarchical Idle State Coordinator

This block turns per-thread idle requests into one resolved idle state per core and one for the whole package. It models a small multi-core processor in which every core runs two hardware threads. Each thread asks for one of five states: running, halt, low-point halt, sleep or deep sleep. The block registers these requests and filters out illegal moves. It merges each core's threads into a core state, then merges the cores into a package state. The deep package state is gated by a platform grant, and low-point halt entry is run as a two-step frequency-then-voltage handshake.

The clock, voltage and cache-flush machinery sit outside the block. The block sees them only as request and acknowledge pins. A memory or snoop request input stops the package from moving deeper while it is high. It does not stop the package from moving shallower.

Top module: `idle_state_coord`

## Requirements
- R1: A synchronous active-high reset puts every thread, every core and the package in the running state. It also clears the illegal-move flag and drops both handshake requests.
- R2: All state ports use a 3-bit code ordered by depth: running=0, halt=1, low-point halt=2, sleep=3, deep sleep=4. A core's state is the shallowest of its two threads' registered states. It appears one cycle after the requests are sampled. A running thread keeps the core running, and a halt thread paired with a sleep thread gives halt.
- R3: A thread may move only between running and an idle state, or stay where it is. A request that is not allowed is rejected and the thread keeps its previous state. Requests are packed three bits per thread, thread t of core c at bit (2c+t)*3. Rejected requests are a move from one idle code to a different idle code, or a code of 5 to 7. Any rejected request sets the sticky illegal-move flag until reset.
- R4: The package state is the shallowest of all core states, one cycle after the core states. It is running whenever any core is running.
- R5: The package reaches deep sleep only when every core is in deep sleep and the platform grant is high. With every core in deep sleep and no grant, the package sits in sleep.
- R6: If the grant drops while the package is in deep sleep, the package moves to sleep on the next clock edge.
- R7: To enter low-point halt, the package first reports halt and raises the frequency request. The voltage request rises only on the edge after the frequency acknowledge is seen. The package reports low-point halt on the edge after the voltage acknowledge. Both requests stay high while the package holds low-point halt.
- R8: If the resolved target stops being low-point halt during the handshake or while holding it, the package returns to running on the next edge and both requests drop.
- R9: While the memory/snoop input is high, the package never moves to a deeper state and the handshake does not advance. Moves to a shallower state still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_req | input | NUM_CORES*THREADS_PER_CORE*3 | Per-thread requested state, thread t of core c at bit (c*THREADS_PER_CORE+t)*3 |
| platform_grant | input | 1 | Platform permission for package deep sleep |
| mem_snoop | input | 1 | Memory or snoop traffic pending; blocks deeper package moves |
| freq_ack | input | 1 | Lowest-frequency request acknowledged |
| volt_ack | input | 1 | Voltage reduction acknowledged |
| core_state | output | NUM_CORES*3 | Resolved state per core, core c at bit c*3 |
| pkg_state | output | 3 | Resolved package state |
| freq_req | output | 1 | Request for the lowest core frequency |
| volt_req | output | 1 | Request for the reduced voltage |
| illegal_seen | output | 1 | Sticky flag: a thread request was rejected |

## Verification
The bench targets the corner cases that break a naive design. The first is a thread asked to jump straight from deep sleep to sleep: a design that accepts it would show the core dropping to sleep. The second is an out-of-range code, which a design that failed to reject it would let pull the core deeper. The bench also runs all cores in deep sleep with the grant absent, withdrawn and re-given. A missing gate or missing fallback would leave the package in deep sleep. It holds the frequency acknowledge low to catch a voltage request raised too early. It removes the low-point target in the middle of the handshake to catch a design that stalls instead of returning to running. Finally it raises the snoop input while a deeper state becomes legal, to catch a package that drifts deeper or refuses to move shallower.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

    localparam int ST_W = 3;

    // Depth-ordered state code: a larger value is a deeper idle state.
    typedef enum logic [ST_W-1:0] {
        ST_RUN      = 3'd0,
        ST_HALT     = 3'd1,
        ST_HALT_LOW = 3'd2,
        ST_SLEEP    = 3'd3,
        ST_DEEP     = 3'd4
    } idle_st_e;

    // Phases of the low-point halt entry handshake.
    typedef enum logic [1:0] {
        SQ_OFF  = 2'd0,
        SQ_FREQ = 2'd1,
        SQ_VOLT = 2'd2,
        SQ_HELD = 2'd3
    } lowpt_seq_e;

    function automatic logic code_valid(input logic [ST_W-1:0] v);
        return v <= ST_W'(ST_DEEP);
    endfunction

    // A thread may leave or enter running, or keep its state; nothing else.
    function automatic logic move_ok(input idle_st_e cur, input logic [ST_W-1:0] nxt);
        logic via_run;
        via_run = (cur == ST_RUN) || (nxt == ST_W'(ST_RUN)) || (nxt == ST_W'(cur));
        return code_valid(nxt) && via_run;
    endfunction

    function automatic idle_st_e shallower(input idle_st_e a, input idle_st_e b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/idle_thread_bank.sv
module idle_thread_bank
    import idle_coord_pkg::*;
#(
    parameter int N_THREADS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_THREADS*ST_W-1:0] req,
    output logic [N_THREADS*ST_W-1:0] st,
    output logic [N_THREADS-1:0]      rejected
);

    for (genvar i = 0; i < N_THREADS; i++) begin : g_thr
        idle_st_e          cur_q;
        logic [ST_W-1:0]   want;
        logic              ok;

        assign want = req[i*ST_W +: ST_W];
        assign ok   = move_ok(cur_q, want);

        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q <= ST_RUN;
            end else if (ok) begin
                cur_q <= idle_st_e'(want);
            end
        end

        assign st[i*ST_W +: ST_W] = cur_q;
        assign rejected[i]        = ~ok;
    end

endmodule

// File: rtl/idle_core_merge.sv
module idle_core_merge
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES        = 4,
    parameter int THREADS_PER_CORE = 2
) (
    input  logic [NUM_CORES*THREADS_PER_CORE*ST_W-1:0] thr_st,
    output logic [NUM_CORES*ST_W-1:0]                  core_st
);

    localparam int CORE_BITS = THREADS_PER_CORE * ST_W;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        idle_st_e merged;

        always_comb begin
            merged = ST_DEEP;
            for (int t = 0; t < THREADS_PER_CORE; t++) begin
                merged = shallower(merged,
                                   idle_st_e'(thr_st[c*CORE_BITS + t*ST_W +: ST_W]));
            end
        end

        assign core_st[c*ST_W +: ST_W] = merged;
    end

endmodule

// File: rtl/idle_pkg_ctrl.sv
module idle_pkg_ctrl
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CORES*ST_W-1:0] core_st,
    input  logic                      grant,
    input  logic                      snoop,
    input  logic                      freq_ack,
    input  logic                      volt_ack,
    output logic [ST_W-1:0]           pkg_st,
    output logic                      freq_req,
    output logic                      volt_req
);

    idle_st_e   pkg_q, pkg_n;
    lowpt_seq_e seq_q, seq_n;
    idle_st_e   tgt;
    idle_st_e   eff;

    // Shallowest core state across the package.
    always_comb begin
        tgt = ST_DEEP;
        for (int c = 0; c < NUM_CORES; c++) begin
            tgt = shallower(tgt, idle_st_e'(core_st[c*ST_W +: ST_W]));
        end
    end

    // Deep sleep everywhere still needs the platform's permission.
    assign eff = (tgt == ST_DEEP && !grant) ? ST_SLEEP : tgt;

    always_comb begin
        pkg_n = pkg_q;
        seq_n = seq_q;
        if (seq_q != SQ_OFF) begin
            if (eff != ST_HALT_LOW) begin
                pkg_n = ST_RUN;
                seq_n = SQ_OFF;
            end else begin
                case (seq_q)
                    SQ_FREQ: if (freq_ack && !snoop) seq_n = SQ_VOLT;
                    SQ_VOLT: if (volt_ack && !snoop) begin
                        seq_n = SQ_HELD;
                        pkg_n = ST_HALT_LOW;
                    end
                    default: ;
                endcase
            end
        end else if (eff == ST_HALT_LOW) begin
            if (!snoop) begin
                pkg_n = ST_HALT;
                seq_n = SQ_FREQ;
            end else if (pkg_q > ST_HALT) begin
                pkg_n = ST_HALT;
            end
        end else if (!(snoop && (eff > pkg_q))) begin
            pkg_n = eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkg_q <= ST_RUN;
            seq_q <= SQ_OFF;
        end else begin
            pkg_q <= pkg_n;
            seq_q <= seq_n;
        end
    end

    assign pkg_st   = pkg_q;
    assign freq_req = (seq_q != SQ_OFF);
    assign volt_req = (seq_q == SQ_VOLT) || (seq_q == SQ_HELD);

endmodule

// File: rtl/idle_state_coord.sv
module idle_state_coord
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES        = 4,
    parameter int THREADS_PER_CORE = 2
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [NUM_CORES*THREADS_PER_CORE*ST_W-1:0] thr_req,
    input  logic                                       platform_grant,
    input  logic                                       mem_snoop,
    input  logic                                       freq_ack,
    input  logic                                       volt_ack,
    output logic [NUM_CORES*ST_W-1:0]                  core_state,
    output logic [ST_W-1:0]                            pkg_state,
    output logic                                       freq_req,
    output logic                                       volt_req,
    output logic                                       illegal_seen
);

    localparam int N_THREADS = NUM_CORES * THREADS_PER_CORE;

    logic [N_THREADS*ST_W-1:0] thr_st;
    logic [N_THREADS-1:0]      rejected;
    logic                      flag_q;

    idle_thread_bank #(.N_THREADS(N_THREADS)) u_threads (
        .clk      (clk),
        .rst      (rst),
        .req      (thr_req),
        .st       (thr_st),
        .rejected (rejected)
    );

    idle_core_merge #(
        .NUM_CORES        (NUM_CORES),
        .THREADS_PER_CORE (THREADS_PER_CORE)
    ) u_cores (
        .thr_st  (thr_st),
        .core_st (core_state)
    );

    idle_pkg_ctrl #(.NUM_CORES(NUM_CORES)) u_pkg (
        .clk      (clk),
        .rst      (rst),
        .core_st  (core_state),
        .grant    (platform_grant),
        .snoop    (mem_snoop),
        .freq_ack (freq_ack),
        .volt_ack (volt_ack),
        .pkg_st   (pkg_state),
        .freq_req (freq_req),
        .volt_req (volt_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (|rejected) begin
            flag_q <= 1'b1;
        end
    end

    assign illegal_seen = flag_q;

endmodule

// File: rtl/idle_state_coord_chk.sv
module idle_state_coord_chk
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      platform_grant,
    input logic                      mem_snoop,
    input logic                      freq_ack,
    input logic [NUM_CORES*ST_W-1:0] core_state,
    input logic [ST_W-1:0]           pkg_state,
    input logic                      freq_req,
    input logic                      volt_req,
    input logic                      illegal_seen
);

    logic all_deep;
    logic none_running;

    always_comb begin
        all_deep     = 1'b1;
        none_running = 1'b1;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core_state[c*ST_W +: ST_W] != ST_W'(ST_DEEP)) all_deep = 1'b0;
            if (core_state[c*ST_W +: ST_W] == ST_W'(ST_RUN))  none_running = 1'b0;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pkg_state == 3'd0 && !illegal_seen && !freq_req && !volt_req)); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(illegal_seen) |-> illegal_seen); // R3

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
        AST_CORE_VIA_RUN: assert property (@(posedge clk) disable iff (rst)
            ($past(core_state[c*ST_W +: ST_W]) != 3'd0 && core_state[c*ST_W +: ST_W] != 3'd0)
            |-> (core_state[c*ST_W +: ST_W] == $past(core_state[c*ST_W +: ST_W]))); // R3
    end

    AST_PKG_IDLE_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pkg_state != 3'd0) |-> $past(none_running)); // R4

    AST_DEEP_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (pkg_state == 3'd4) |-> ($past(platform_grant) && $past(all_deep))); // R5

    AST_GRANT_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        ($past(pkg_state) == 3'd4 && !$past(platform_grant)) |-> (pkg_state != 3'd4)); // R6

    AST_VOLT_AFTER_FREQ: assert property (@(posedge clk) disable iff (rst)
        $rose(volt_req) |-> (freq_req && $past(freq_ack))); // R7

    AST_VOLT_NEEDS_FREQ: assert property (@(posedge clk) disable iff (rst)
        volt_req |-> freq_req); // R7

    AST_SNOOP_NO_DEEPER: assert property (@(posedge clk) disable iff (rst)
        (pkg_state > $past(pkg_state)) |-> !$past(mem_snoop)); // R9

endmodule

bind idle_state_coord idle_state_coord_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .platform_grant (platform_grant),
    .mem_snoop      (mem_snoop),
    .freq_ack       (freq_ack),
    .core_state     (core_state),
    .pkg_state      (pkg_state),
    .freq_req       (freq_req),
    .volt_req       (volt_req),
    .illegal_seen   (illegal_seen)
);

// File: tb/idle_state_coord_bench.sv
module idle_state_coord_bench;

    localparam int NC = 4;
    localparam int CW = NC * 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC*6-1:0] thr_req = '0;
    logic          platform_grant = 1'b0;
    logic          mem_snoop = 1'b0;
    logic          freq_ack = 1'b0;
    logic          volt_ack = 1'b0;
    logic [CW-1:0] core_state;
    logic [2:0]    pkg_state;
    logic          freq_req;
    logic          volt_req;
    logic          illegal_seen;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int            due;
        logic [CW-1:0] cores;
        logic [2:0]    pkg;
        logic          flag;
        logic          fr;
        logic          vr;
        string         tag;
    } exp_t;

    exp_t sb[$];

    idle_state_coord #(.NUM_CORES(NC), .THREADS_PER_CORE(2)) u_idle_state_coord (
        .clk            (clk),
        .rst            (rst),
        .thr_req        (thr_req),
        .platform_grant (platform_grant),
        .mem_snoop      (mem_snoop),
        .freq_ack       (freq_ack),
        .volt_ack       (volt_ack),
        .core_state     (core_state),
        .pkg_state      (pkg_state),
        .freq_req       (freq_req),
        .volt_req       (volt_req),
        .illegal_seen   (illegal_seen)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [CW-1:0] pk(input logic [2:0] a, input logic [2:0] b,
                                         input logic [2:0] c, input logic [2:0] d);
        return {d, c, b, a};
    endfunction

    task automatic set_core(input int c, input logic [2:0] a, input logic [2:0] b);
        thr_req[(c*2)*3 +: 3]   = a;
        thr_req[(c*2+1)*3 +: 3] = b;
    endtask

    task automatic set_all(input logic [2:0] v);
        for (int c = 0; c < NC; c++) set_core(c, v, v);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int lat, input logic [CW-1:0] cores, input logic [2:0] pkg,
                        input logic flag, input logic fr, input logic vr, input string tag);
        exp_t e;
        e.due = cyc + lat; e.cores = cores; e.pkg = pkg;
        e.flag = flag; e.fr = fr; e.vr = vr; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares the head of the scoreboard when its cycle comes due.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (core_state !== e.cores || pkg_state !== e.pkg || illegal_seen !== e.flag ||
                    freq_req !== e.fr || volt_req !== e.vr) begin
                    bad++;
                    $display("FAIL %s: got cores=%h pkg=%0d flag=%b fr=%b vr=%b exp cores=%h pkg=%0d flag=%b fr=%b vr=%b",
                             e.tag, core_state, pkg_state, illegal_seen, freq_req, volt_req,
                             e.cores, e.pkg, e.flag, e.fr, e.vr);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        push(1, pk(0,0,0,0), 0, 0, 0, 0, "R1 reset state"); tick(2);

        set_core(0, 3, 1);
        push(1, pk(1,0,0,0), 0, 0, 0, 0, "R2 halt beats sleep"); tick(2);
        set_core(1, 6, 0);
        set_core(2, 4, 4);
        // 6 above is an invalid code on an idle-to-running pair; thread t0 of core 1 stays 0
        push(1, pk(1,0,4,0), 0, 1, 0, 0, "R2 running dominates, R3 code 6 rejected"); tick(2);
        set_core(1, 4, 0);
        push(1, pk(1,0,4,0), 0, 1, 0, 0, "R2 running thread keeps core running"); tick(2);
        set_core(2, 3, 3);
        push(1, pk(1,0,4,0), 0, 1, 0, 0, "R3 deep to sleep rejected"); tick(2);

        set_core(1, 4, 4); set_core(2, 4, 4); set_core(3, 3, 3);
        push(2, pk(1,4,4,3), 1, 1, 0, 0, "R4 package halt"); tick(3);
        set_core(0, 3, 0);
        push(2, pk(0,4,4,3), 0, 1, 0, 0, "R4 any running core"); tick(3);
        set_core(0, 3, 3);
        push(2, pk(3,4,4,3), 3, 1, 0, 0, "R4 package sleep"); tick(3);

        set_core(0, 0, 0); set_core(3, 0, 0); tick(3);
        set_core(0, 4, 4); set_core(3, 4, 4); platform_grant = 1'b0;
        push(2, pk(4,4,4,4), 3, 1, 0, 0, "R5 no grant gives sleep"); tick(3);
        platform_grant = 1'b1;
        push(1, pk(4,4,4,4), 4, 1, 0, 0, "R5 grant gives deep"); tick(2);
        platform_grant = 1'b0;
        push(1, pk(4,4,4,4), 3, 1, 0, 0, "R6 grant withdrawn"); tick(2);

        platform_grant = 1'b1; mem_snoop = 1'b1;
        push(1, pk(4,4,4,4), 3, 1, 0, 0, "R9 snoop holds shallow");
        push(2, pk(4,4,4,4), 3, 1, 0, 0, "R9 snoop still holds"); tick(3);
        mem_snoop = 1'b0;
        push(1, pk(4,4,4,4), 4, 1, 0, 0, "R9 release deepens"); tick(2);
        mem_snoop = 1'b1; set_core(0, 0, 0);
        push(2, pk(0,4,4,4), 0, 1, 0, 0, "R9 shallower allowed"); tick(3);
        mem_snoop = 1'b0;

        set_all(0); tick(3);
        set_all(2);
        push(2, pk(2,2,2,2), 1, 1, 1, 0, "R7 frequency first");
        push(4, pk(2,2,2,2), 1, 1, 1, 0, "R7 waits for freq ack"); tick(5);
        freq_ack = 1'b1;
        push(1, pk(2,2,2,2), 1, 1, 1, 1, "R7 voltage after freq ack"); tick(2);
        volt_ack = 1'b1;
        push(1, pk(2,2,2,2), 2, 1, 1, 1, "R7 low-point halt reached"); tick(2);

        freq_ack = 1'b0; volt_ack = 1'b0; set_all(0);
        push(2, pk(0,0,0,0), 0, 1, 0, 0, "R8 exit from held"); tick(3);
        set_all(2); tick(3);
        set_core(3, 0, 2);
        push(1, pk(2,2,2,0), 1, 1, 1, 0, "R8 mid-handshake");
        push(2, pk(2,2,2,0), 0, 1, 0, 0, "R8 abort to running"); tick(3);

        rst = 1'b1; set_all(0); platform_grant = 1'b0; tick(2);
        rst = 1'b0;
        push(1, pk(0,0,0,0), 0, 0, 0, 0, "R1 reset clears flag"); tick(2);
        set_core(3, 3, 7);
        push(1, pk(0,0,0,0), 0, 1, 0, 0, "R3 out-of-range code"); tick(3);

        done = 1'b1;
        if (sb.size() > 0) begin
            total += sb.size();
            bad   += sb.size();
            $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule